// File: doc/BRIEF.md
# SDRAM Command Decoder and Sequencing Checker

This block sits passively on the command pins of a four-bank synchronous DRAM. It samples them on every rising clock edge and turns each cycle into a command code. It keeps a small model of every bank: whether the bank is idle or open, whether a burst is still running, and whether that burst will close the bank on its own when it ends. It uses that model to reject commands that break the sequencing rules. It also produces the data-mask strobes, which have different latencies for the write path and the read path.

A rejected command shows up as a one-cycle flag with a 3-bit reason code. A rejected command leaves the bank model and the mode setting unchanged, and decoding continues on the next cycle. The burst length is taken from the mode-set value, so the checker knows when a burst ends and when an auto-precharge has closed its bank.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Each sampled edge is decoded into `cmd_code`, registered one cycle later, with these values: 0 deselect (`cs_n` high), 1 no-op, 2 mode set, 3 auto refresh, 4 self-refresh entry, 5 activate, 6 read, 7 read with auto-precharge, 8 write, 9 write with auto-precharge, 10 precharge one bank, 11 precharge all, 12 burst stop, 13 suspended. With `cs_n` low, `{ras_n,cas_n,we_n}` is decoded as follows: 000 mode set, 001 refresh, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 111 no-op. On read, write and precharge, `addr_ap` high selects the auto-precharge or all-banks variant.
- R2: `ba` value 0, 1, 2 or 3 selects the bank shown in bit 0, 1, 2 or 3 of `bank_open` and `bank_burst`.
- R3: A mode set while any bank is open is rejected with reason 1.
- R4: In the two cycles after an accepted mode set, any command other than no-op, deselect or suspended is rejected with reason 2. This check has the highest priority.
- R5: An auto refresh or a self-refresh entry while any bank is open is rejected with reason 3.
- R6: An activate to an open bank is rejected with reason 6. A read or write to an idle bank is rejected with reason 5.
- R7: While a bank runs a burst with auto-precharge, a read or write to that bank is rejected with reason 4. The bank becomes idle on the edge that ends its burst, which is BL-1 edges after the command.
- R8: A read or write to another bank is rejected with reason 7 while an auto-precharge burst is still running. It is accepted once that burst's length has elapsed.
- R9: An accepted mode set takes the burst length from `addr_bl`: 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, and any other value gives 8. The default after reset is 1. With 1 beat, a read or write with auto-precharge closes the bank at once.
- R10: Precharge with `addr_ap` low closes the selected bank. With `addr_ap` high it closes all banks. Burst stop ends every burst that has no auto-precharge.
- R11: `viol` is high for exactly the cycle after each rejected command and low after every accepted one. A rejected command changes no bank state.
- R12: `wr_mask` shows `dqm` as sampled at the same edge as the command (write latency 0).
- R13: `rd_hiz` goes high two edges after `wr_mask` for the same `dqm` sample (read latency 2).
- R14: A refresh sampled with `cke` falling from high to low is a self-refresh entry. Any edge whose previous `cke` sample was low decodes as suspended and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr_ap | input | 1 | Address bit for auto-precharge and all-banks selection |
| addr_bl | input | 3 | Low address bits carrying the burst-length code at mode set |
| dqm | input | 1 | Data mask pin |
| cmd_code | output | 4 | Decoded command of the previous edge |
| bank_open | output | 4 | Per-bank open flag |
| bank_burst | output | 4 | Per-bank burst-in-progress flag |
| viol | output | 1 | Rule violation pulse |
| viol_reason | output | 3 | Reason for the violation, 0 when none |
| wr_mask | output | 1 | Write data mask strobe |
| rd_hiz | output | 1 | Read output high-impedance strobe |

## Verification
A corrupted bank state becomes visible on `bank_open` or `bank_burst` on the edge after it occurs. It also produces a wrong reason code the first time a command is issued to that bank. A burst counter that is off by one shifts the cycle at which an auto-precharged bank reads idle. It also shifts the first edge on which another bank is accepted, so the bench issues commands at exactly those edges. A wrong mode-set window or a wrong mask delay is caught within two or three cycles by the scripted sequences around a mode set and around a single `dqm` pulse.

// File: rtl/smon_pkg.sv
package smon_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_MRS   = 4'd2,
    CMD_AREF  = 4'd3,
    CMD_SREF  = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_RD    = 4'd6,
    CMD_RDA   = 4'd7,
    CMD_WR    = 4'd8,
    CMD_WRA   = 4'd9,
    CMD_PRE   = 4'd10,
    CMD_PREA  = 4'd11,
    CMD_BST   = 4'd12,
    CMD_SUSP  = 4'd13
  } smon_cmd_e;

  typedef enum logic [2:0] {
    V_NONE         = 3'd0,
    V_MRS_BUSY     = 3'd1,
    V_MRS_GAP      = 3'd2,
    V_REF_BUSY     = 3'd3,
    V_AP_SAME      = 3'd4,
    V_NOT_OPEN     = 3'd5,
    V_ALREADY_OPEN = 3'd6,
    V_AP_OTHER     = 3'd7
  } smon_viol_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_AUTOPRE = 2'd2
  } smon_bank_e;

  function automatic logic cmd_is_quiet(smon_cmd_e c);
    return (c == CMD_NOP) || (c == CMD_DESEL) || (c == CMD_SUSP);
  endfunction

  function automatic logic cmd_is_rw(smon_cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
  endfunction

  function automatic logic cmd_is_ap(smon_cmd_e c);
    return (c == CMD_RDA) || (c == CMD_WRA);
  endfunction

endpackage

// File: rtl/smon_decode.sv
module smon_decode
  import smon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cke_i,
  input  logic      cs_ni,
  input  logic      ras_ni,
  input  logic      cas_ni,
  input  logic      we_ni,
  input  logic      ap_i,
  output smon_cmd_e cmd_o
);

  logic       cke_prev_q;
  logic [2:0] rcw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_prev_q <= 1'b1;
    else         cke_prev_q <= cke_i;
  end

  assign rcw = {ras_ni, cas_ni, we_ni};

  always_comb begin
    cmd_o = CMD_NOP;
    if (!cke_prev_q) begin
      cmd_o = CMD_SUSP;
    end else if (cs_ni) begin
      cmd_o = CMD_DESEL;
    end else begin
      unique case (rcw)
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = cke_i ? CMD_AREF : CMD_SREF;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = ap_i ? CMD_RDA : CMD_RD;
        3'b100:  cmd_o = ap_i ? CMD_WRA : CMD_WR;
        3'b010:  cmd_o = ap_i ? CMD_PREA : CMD_PRE;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

  a_r14_susp_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> (cmd_o == CMD_SUSP));

endmodule

// File: rtl/smon_rules.sv
module smon_rules
  import smon_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int MRS_GAP = 2,
  parameter int MAX_BL  = 8,
  localparam int GAP_W  = $clog2(MRS_GAP + 1),
  localparam int CNT_W  = $clog2(MAX_BL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  smon_cmd_e        cmd_i,
  input  logic [BANKS-1:0] sel_i,
  input  logic [BANKS-1:0] open_i,
  input  logic [BANKS-1:0] autopre_i,
  input  logic [2:0]       bl_code_i,
  output logic             accept_o,
  output logic [CNT_W-1:0] bl_m1_o,
  output logic             viol_o,
  output logic [2:0]       reason_o
);

  smon_viol_e       reason_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [CNT_W-1:0] bl_m1_q, bl_m1_d;
  logic             tgt_open, tgt_ap, other_ap, any_open;

  assign tgt_open = |(open_i & sel_i);
  assign tgt_ap   = |(autopre_i & sel_i);
  assign other_ap = |(autopre_i & ~sel_i);
  assign any_open = |open_i;

  always_comb begin
    reason_d = V_NONE;
    if ((gap_q != '0) && !cmd_is_quiet(cmd_i)) begin
      reason_d = V_MRS_GAP;
    end else if (cmd_i == CMD_MRS) begin
      if (any_open) reason_d = V_MRS_BUSY;
    end else if ((cmd_i == CMD_AREF) || (cmd_i == CMD_SREF)) begin
      if (any_open) reason_d = V_REF_BUSY;
    end else if (cmd_i == CMD_ACT) begin
      if (tgt_open) reason_d = V_ALREADY_OPEN;
    end else if (cmd_is_rw(cmd_i)) begin
      if (!tgt_open)     reason_d = V_NOT_OPEN;
      else if (tgt_ap)   reason_d = V_AP_SAME;
      else if (other_ap) reason_d = V_AP_OTHER;
    end
  end

  assign accept_o = (reason_d == V_NONE);

  always_comb begin
    gap_d   = gap_q;
    bl_m1_d = bl_m1_q;
    if (gap_q != '0) gap_d = gap_q - 1'b1;
    if (accept_o && (cmd_i == CMD_MRS)) begin
      gap_d = GAP_W'(MRS_GAP);
      unique case (bl_code_i)
        3'd0:    bl_m1_d = CNT_W'(0);
        3'd1:    bl_m1_d = CNT_W'(1);
        3'd2:    bl_m1_d = CNT_W'(3);
        default: bl_m1_d = CNT_W'(MAX_BL - 1);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q    <= '0;
      bl_m1_q  <= '0;
      viol_o   <= 1'b0;
      reason_o <= 3'd0;
    end else begin
      gap_q    <= gap_d;
      bl_m1_q  <= bl_m1_d;
      viol_o   <= !accept_o;
      reason_o <= reason_d;
    end
  end

  assign bl_m1_o = bl_m1_q;

  a_r4_mrs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gap_q != '0) && !cmd_is_quiet(cmd_i)) |=> (viol_o && (reason_o == 3'd2)));

  a_r3_mrs_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == CMD_MRS) && (|open_i)) |=> viol_o);

  a_r5_ref_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cmd_i == CMD_AREF) || (cmd_i == CMD_SREF)) && (|open_i)) |=> viol_o);

endmodule

// File: rtl/smon_bank.sv
module smon_bank
  import smon_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             rw_i,
  input  logic             ap_i,
  input  logic             pre_i,
  input  logic             bst_i,
  input  logic [CNT_W-1:0] bl_m1_i,
  output logic             open_o,
  output logic             autopre_o,
  output logic             busy_o
);

  smon_bank_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    if ((st_q == BK_AUTOPRE) && (cnt_q == CNT_W'(1))) st_d = BK_IDLE;
    if (act_i) st_d = BK_OPEN;
    if (rw_i) begin
      cnt_d = bl_m1_i;
      if (ap_i) st_d = (bl_m1_i == '0) ? BK_IDLE : BK_AUTOPRE;
    end
    if (bst_i && (st_q == BK_OPEN)) cnt_d = '0;
    if (pre_i) begin
      st_d  = BK_IDLE;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign open_o    = (st_q != BK_IDLE);
  assign autopre_o = (st_q == BK_AUTOPRE);
  assign busy_o    = (cnt_q != '0);

  a_r6_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (open_o && !busy_o));

  a_r7_ap_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (autopre_o && (cnt_q == CNT_W'(1)) && !pre_i) |=> !open_o);

  a_r10_pre_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |=> (!open_o && !busy_o));

endmodule

// File: rtl/smon_mask.sv
module smon_mask #(
  parameter int RD_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dqm_i,
  output logic wr_mask_o,
  output logic rd_hiz_o
);

  logic [RD_LAT:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= 1'b0;
    else         pipe_q[0] <= dqm_i;
  end

  for (genvar i = 1; i <= RD_LAT; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= 1'b0;
      else         pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign wr_mask_o = pipe_q[0];
  assign rd_hiz_o  = pipe_q[RD_LAT];

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  if (RD_LAT == 2) begin : g_chk
    a_r13_read_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd3) |-> (rd_hiz_o == $past(dqm_i, 3)));
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import smon_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int MRS_GAP = 2,
  parameter int MAX_BL  = 8,
  parameter int RD_LAT  = 2,
  localparam int BA_W   = $clog2(BANKS),
  localparam int CNT_W  = $clog2(MAX_BL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic             addr_ap,
  input  logic [2:0]       addr_bl,
  input  logic             dqm,
  output logic [3:0]       cmd_code,
  output logic [BANKS-1:0] bank_open,
  output logic [BANKS-1:0] bank_burst,
  output logic             viol,
  output logic [2:0]       viol_reason,
  output logic             wr_mask,
  output logic             rd_hiz
);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  smon_cmd_e        cmd;
  logic [BANKS-1:0] sel, autopre;
  logic             accept;
  logic [CNT_W-1:0] bl_m1;

  smon_decode i_decode (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .cke_i  (cke),
    .cs_ni  (cs_n),
    .ras_ni (ras_n),
    .cas_ni (cas_n),
    .we_ni  (we_n),
    .ap_i   (addr_ap),
    .cmd_o  (cmd)
  );

  smon_rules #(
    .BANKS   (BANKS),
    .MRS_GAP (MRS_GAP),
    .MAX_BL  (MAX_BL)
  ) i_rules (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .sel_i     (sel),
    .open_i    (bank_open),
    .autopre_i (autopre),
    .bl_code_i (addr_bl),
    .accept_o  (accept),
    .bl_m1_o   (bl_m1),
    .viol_o    (viol),
    .reason_o  (viol_reason)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign sel[b] = (ba == BA_W'(b));

    smon_bank #(.CNT_W(CNT_W)) i_bank (
      .clk_i     (clk),
      .rst_ni    (rst_ni),
      .act_i     (accept && (cmd == CMD_ACT) && sel[b]),
      .rw_i      (accept && cmd_is_rw(cmd) && sel[b]),
      .ap_i      (cmd_is_ap(cmd)),
      .pre_i     (accept && (((cmd == CMD_PRE) && sel[b]) || (cmd == CMD_PREA))),
      .bst_i     (accept && (cmd == CMD_BST)),
      .bl_m1_i   (bl_m1),
      .open_o    (bank_open[b]),
      .autopre_o (autopre[b]),
      .busy_o    (bank_burst[b])
    );
  end

  smon_mask #(.RD_LAT(RD_LAT)) i_mask (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .dqm_i     (dqm),
    .wr_mask_o (wr_mask),
    .rd_hiz_o  (rd_hiz)
  );

  logic [3:0] cmd_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= 4'd0;
    else         cmd_q <= cmd;
  end
  assign cmd_code = cmd_q;

  a_r11_reject_keeps_state: assert property (@(posedge clk) disable iff (!rst_ni)
    (!accept && (cmd == CMD_ACT)) |=> $stable(bank_open));

endmodule

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;

  localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_ACT = 3'b011,
                         K_RD  = 3'b101, K_WR  = 3'b100, K_PRE = 3'b010,
                         K_BST = 3'b110, K_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_n;
  logic cke, cs_n, ras_n, cas_n, we_n, addr_ap, dqm;
  logic [1:0] ba;
  logic [2:0] addr_bl;
  logic [3:0] cmd_code, bank_open, bank_burst;
  logic viol, wr_mask, rd_hiz;
  logic [2:0] viol_reason;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_cmd_monitor i_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr_ap(addr_ap), .addr_bl(addr_bl),
    .dqm(dqm), .cmd_code(cmd_code), .bank_open(bank_open),
    .bank_burst(bank_burst), .viol(viol), .viol_reason(viol_reason),
    .wr_mask(wr_mask), .rd_hiz(rd_hiz)
  );

  typedef struct {
    logic [3:0] code;
    logic [2:0] rsn;
    string      tag;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic ck, input logic csn, input logic [2:0] rcw,
                      input logic [1:0] b, input logic ap, input logic [2:0] bl,
                      input logic dm, input logic [3:0] ec, input logic [2:0] er,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cke = ck; cs_n = csn; {ras_n, cas_n, we_n} = rcw;
    ba = b; addr_ap = ap; addr_bl = bl; dqm = dm;
    e.code = ec; e.rsn = er; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [2:0] rcw, input logic [1:0] b, input logic ap,
                     input logic [2:0] bl, input logic [3:0] ec, input logic [2:0] er,
                     input string tag);
    tick(1'b1, 1'b0, rcw, b, ap, bl, 1'b0, ec, er, tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " code"}, 32'(cmd_code), 32'(e.code));
        chk({e.tag, " reason"}, 32'(viol_reason), 32'(e.rsn));
        chk({e.tag, " R11 pulse"}, 32'(viol), 32'(e.rsn != 3'd0));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = K_NOP;
    ba = 2'd0; addr_ap = 1'b0; addr_bl = 3'd0; dqm = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("reset cmd_code", 32'(cmd_code), 0);
    chk("reset viol", 32'(viol), 0);
    chk("reset bank_open", 32'(bank_open), 0);
    chk("reset bank_burst", 32'(bank_burst), 0);
    chk("reset masks", 32'({wr_mask, rd_hiz}), 0);

    cmd(K_MRS, 2'd0, 1'b0, 3'd2, 4'd2, 3'd0, "R9 mode set BL4");
    cmd(K_ACT, 2'd1, 1'b0, 3'd0, 4'd5, 3'd2, "R4 act in gap");
    chk("R11 rejected act no state", 32'(bank_open), 0);
    cmd(K_NOP, 2'd0, 1'b0, 3'd0, 4'd1, 3'd0, "R4 nop in gap");
    cmd(K_ACT, 2'd1, 1'b0, 3'd0, 4'd5, 3'd0, "R2 act bank1");
    chk("R2 bank1 open", 32'(bank_open), 32'h2);
    cmd(K_ACT, 2'd2, 1'b0, 3'd0, 4'd5, 3'd0, "R2 act bank2");
    chk("R2 bank2 open", 32'(bank_open), 32'h6);
    cmd(K_ACT, 2'd1, 1'b0, 3'd0, 4'd5, 3'd6, "R6 act open bank");
    cmd(K_RD,  2'd0, 1'b0, 3'd0, 4'd6, 3'd5, "R6 read idle bank");
    cmd(K_RD,  2'd1, 1'b1, 3'd0, 4'd7, 3'd0, "R7 read ap bank1");
    chk("R9 burst running", 32'(bank_burst), 32'h2);
    cmd(K_RD,  2'd1, 1'b0, 3'd0, 4'd6, 3'd4, "R7 read same ap bank");
    cmd(K_WR,  2'd2, 1'b0, 3'd0, 4'd8, 3'd7, "R8 write other bank early");
    cmd(K_NOP, 2'd0, 1'b0, 3'd0, 4'd1, 3'd0, "R7 nop");
    chk("R7 ap bank closed", 32'(bank_open), 32'h4);
    cmd(K_WR,  2'd2, 1'b0, 3'd0, 4'd8, 3'd0, "R8 write other bank at BL");
    chk("R8 bank2 burst", 32'(bank_burst), 32'h4);
    cmd(K_BST, 2'd0, 1'b0, 3'd0, 4'd12, 3'd0, "R10 burst stop");
    chk("R10 burst ended", 32'(bank_burst), 0);
    cmd(K_REF, 2'd0, 1'b0, 3'd0, 4'd3, 3'd3, "R5 refresh while open");
    cmd(K_MRS, 2'd0, 1'b0, 3'd0, 4'd2, 3'd1, "R3 mode set while open");
    cmd(K_PRE, 2'd2, 1'b0, 3'd0, 4'd10, 3'd0, "R10 precharge bank2");
    chk("R10 bank2 closed", 32'(bank_open), 0);
    cmd(K_ACT, 2'd3, 1'b0, 3'd0, 4'd5, 3'd0, "R2 act bank3");
    chk("R2 bank3 open", 32'(bank_open), 32'h8);
    cmd(K_ACT, 2'd0, 1'b0, 3'd0, 4'd5, 3'd0, "R2 act bank0");
    chk("R2 bank0 open", 32'(bank_open), 32'h9);
    cmd(K_PRE, 2'd1, 1'b1, 3'd0, 4'd11, 3'd0, "R10 precharge all");
    chk("R10 all closed", 32'(bank_open), 0);
    cmd(K_REF, 2'd0, 1'b0, 3'd0, 4'd3, 3'd0, "R5 refresh idle");
    cmd(K_MRS, 2'd0, 1'b0, 3'd0, 4'd2, 3'd0, "R9 mode set BL1");
    cmd(K_NOP, 2'd0, 1'b0, 3'd0, 4'd1, 3'd0, "R4 gap nop 1");
    cmd(K_NOP, 2'd0, 1'b0, 3'd0, 4'd1, 3'd0, "R4 gap nop 2");
    cmd(K_ACT, 2'd0, 1'b0, 3'd0, 4'd5, 3'd0, "R4 act after gap");
    cmd(K_WR,  2'd0, 1'b1, 3'd0, 4'd9, 3'd0, "R9 write ap BL1");
    chk("R9 BL1 closes at once", 32'({bank_open, bank_burst}), 0);

    tick(1'b0, 1'b0, K_REF, 2'd0, 1'b0, 3'd0, 1'b0, 4'd4, 3'd0, "R14 self refresh entry");
    tick(1'b0, 1'b0, K_ACT, 2'd0, 1'b0, 3'd0, 1'b0, 4'd13, 3'd0, "R14 suspended");
    chk("R14 suspended act ignored", 32'(bank_open), 0);
    tick(1'b1, 1'b0, K_NOP, 2'd0, 1'b0, 3'd0, 1'b0, 4'd13, 3'd0, "R14 exit edge");
    cmd(K_NOP, 2'd0, 1'b0, 3'd0, 4'd1, 3'd0, "R1 nop");
    tick(1'b1, 1'b1, K_MRS, 2'd0, 1'b0, 3'd0, 1'b0, 4'd0, 3'd0, "R1 deselect");

    tick(1'b1, 1'b0, K_NOP, 2'd0, 1'b0, 3'd0, 1'b1, 4'd1, 3'd0, "R12 dqm pulse");
    chk("R12 write mask same edge", 32'(wr_mask), 1);
    chk("R13 read mask not yet", 32'(rd_hiz), 0);
    cmd(K_NOP, 2'd0, 1'b0, 3'd0, 4'd1, 3'd0, "R13 nop a");
    chk("R12 write mask drops", 32'(wr_mask), 0);
    chk("R13 read mask still low", 32'(rd_hiz), 0);
    cmd(K_NOP, 2'd0, 1'b0, 3'd0, 4'd1, 3'd0, "R13 nop b");
    chk("R13 read mask two later", 32'(rd_hiz), 1);
    cmd(K_NOP, 2'd0, 1'b0, 3'd0, 4'd1, 3'd0, "R13 nop c");
    chk("R13 read mask drops", 32'(rd_hiz), 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule